// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the interlock and forwarding controller for a five-stage in-order integer pipeline: fetch, decode/register read, execute/address generation, data-memory access, and writeback. Each cycle the datapath shows it the instruction in decode. That view holds the source register numbers, a flag for each source saying whether it is read, the destination, write-enable, a load flag and a branch flag. For a branch it also carries the taken outcome from the decode-stage comparator. The controller keeps its own record of the destinations of the instructions now in execute and in memory. Against those records it makes every hazard decision during decode.

A decode instruction may read the destination of a load that sits directly ahead of it. In that case the controller raises a stall, which holds the PC and the fetch/decode register and drives a bubble into execute. When a forward can supply the value instead, the controller registers operand-mux selects. Those selects take effect in the consumer's execute cycle. A producer three instructions back needs no action, because the register file writes in the first half-cycle and reads in the second.

Branches resolve in decode and fetch assumes not-taken. A taken branch squashes the one wrong-path instruction already fetched and loads the target into the PC. A branch whose operand is still being produced waits until that value can reach the comparator.

Top module: `hzd_ctrl`

## Requirements
- R1: If execute holds a load whose destination equals a used source of a valid non-branch decode instruction, `stall` is 1 and `pc_sel` is 1 (hold) in that cycle, and both `fwd_a` and `fwd_b` read 0 after the next clock edge (bubble).
- R2: If execute holds a register-writing ALU instruction whose destination equals a used source of a non-branch decode instruction, that operand's select reads 1 (take the execute/memory result) after the next edge.
- R3: If the matching producer is in the memory stage instead (and does not match in execute), the select reads 2 (take the memory/writeback result) after the next edge.
- R4: A producer three instructions ahead, or no dependence at all, gives select 0 (register file) and no stall.
- R5: Register 0 is never a hazard source: reading it, or an older write to it, never causes a stall or a nonzero select.
- R6: When the producers in execute and in memory both match a source, the younger one wins: select 1.
- R7: Unused sources, instructions that do not write a register (stores), and a decode slot marked invalid never cause a stall, flush or forward.
- R8: A valid taken branch in decode that is not stalled gives `flush` = 1 and `pc_sel` = 2 (branch target) in that cycle.
- R9: A not-taken branch that is not stalled gives `flush` = 0 and `pc_sel` = 0 (PC+4).
- R10: A branch whose used source matches a writing instruction in execute (ALU or load), or a load in memory, stalls with `pc_sel` = 1.
- R11: A branch whose used source matches an ALU result in the memory stage raises the comparator bypass `br_fwd_a`/`br_fwd_b` for that operand in the same cycle, without stalling.
- R12: Stall takes priority over flush. A taken branch that must stall has `flush` = 0 and resolves in the cycle its stall clears.
- R13: During and right after reset, `stall`, `flush`, `br_fwd_a` and `br_fwd_b` are 0, `pc_sel` is 0 and both selects are 0, even if the decode instruction names a register an earlier load wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | REG_W | First source register number |
| id_rs2 | input | REG_W | Second source register number |
| id_rs1_used | input | 1 | First source is read |
| id_rs2_used | input | 1 | Second source is read |
| id_rd | input | REG_W | Destination register number |
| id_reg_write | input | 1 | Instruction writes a register |
| id_load | input | 1 | Instruction is a load |
| id_branch | input | 1 | Instruction is a conditional branch |
| id_br_taken | input | 1 | Decode comparator outcome for the branch |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |
| flush | output | 1 | Squash the fetched wrong-path instruction |
| pc_sel | output | 2 | 0 PC+4, 1 hold, 2 branch target |
| fwd_a | output | 2 | Execute operand A select: 0 regfile, 1 exe/mem, 2 mem/wb |
| fwd_b | output | 2 | Execute operand B select, same coding |
| br_fwd_a | output | 1 | Branch comparator A takes the exe/mem result |
| br_fwd_b | output | 1 | Branch comparator B takes the exe/mem result |

## Verification
A stale or wrong destination record for execute or memory shows up at the ports in the same cycle as a stall that is missing or spurious, or as a wrong `br_fwd` bit. It also shows one edge later as a wrong operand select for the instruction that enters execute. A record that fails to shift from execute into memory turns a distance-two select of 2 into 0. It also lets a load's stall be skipped for a waiting branch. Both are visible within two cycles of the producer leaving decode.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        FWD_REGF  = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2
    } fwd_sel_e;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_HOLD   = 2'd1,
        PC_TARGET = 2'd2
    } pc_sel_e;

endpackage

// File: rtl/hzd_stage_trk.sv
// Destination records for the instructions in execute and memory.
module hzd_stage_trk #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [REG_W-1:0] in_rd,
    input  logic             in_wr,
    input  logic             in_ld,
    output logic [REG_W-1:0] ex_rd,
    output logic             ex_wr,
    output logic             ex_ld,
    output logic [REG_W-1:0] mem_rd,
    output logic             mem_wr,
    output logic             mem_ld
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic             wr;
        logic             ld;
    } slot_t;

    typedef struct packed {
        slot_t ex;
        slot_t mem;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.mem = trk_q.ex;
        if (in_valid) begin
            trk_d.ex.rd = in_rd;
            trk_d.ex.wr = in_wr && (in_rd != ZERO_REG);
            trk_d.ex.ld = in_ld && in_wr && (in_rd != ZERO_REG);
        end else begin
            trk_d.ex = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ex_rd  = trk_q.ex.rd;
    assign ex_wr  = trk_q.ex.wr;
    assign ex_ld  = trk_q.ex.ld;
    assign mem_rd = trk_q.mem.rd;
    assign mem_wr = trk_q.mem.wr;
    assign mem_ld = trk_q.mem.ld;
endmodule

// File: rtl/hzd_src_chk.sv
// Per-source dependence check against the in-flight producers.
module hzd_src_chk
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             used,
    input  logic [REG_W-1:0] src,
    input  logic             is_branch,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr,
    input  logic             ex_ld,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr,
    input  logic             mem_ld,
    output logic             stall_req,
    output logic [1:0]       fwd_sel,
    output logic             br_fwd
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic live, hit_ex, hit_mem;
    fwd_sel_e sel;

    always_comb begin
        live    = used && (src != ZERO_REG);
        hit_ex  = live && ex_wr  && (ex_rd  == src);
        hit_mem = live && mem_wr && (mem_rd == src);
        sel     = FWD_REGF;
        br_fwd  = 1'b0;
        if (is_branch) begin
            // comparator sits in decode: only an ALU result in memory can reach it
            stall_req = hit_ex || (hit_mem && mem_ld);
            br_fwd    = hit_mem && !mem_ld && !hit_ex;
        end else begin
            stall_req = hit_ex && ex_ld;
            if (hit_ex)       sel = FWD_EXMEM;
            else if (hit_mem) sel = FWD_MEMWB;
        end
        fwd_sel = sel;
    end
endmodule

// File: rtl/hzd_branch_ctl.sv
// Predict-not-taken redirect with stall priority.
module hzd_branch_ctl
    import hzd_pkg::*;
(
    input  logic       valid,
    input  logic       is_branch,
    input  logic       taken,
    input  logic       stall,
    output logic       flush,
    output logic [1:0] pc_sel
);
    pc_sel_e sel;

    always_comb begin
        flush = valid && is_branch && taken && !stall;
        if (stall)      sel = PC_HOLD;
        else if (flush) sel = PC_TARGET;
        else            sel = PC_SEQ;
        pc_sel = sel;
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs1_used,
    input  logic             id_rs2_used,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_reg_write,
    input  logic             id_load,
    input  logic             id_branch,
    input  logic             id_br_taken,
    output logic             stall,
    output logic             flush,
    output logic [1:0]       pc_sel,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             br_fwd_a,
    output logic             br_fwd_b
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0] ex_rd, mem_rd;
    logic             ex_wr, ex_ld, mem_wr, mem_ld;

    logic [NUM_SRC-1:0][REG_W-1:0] src;
    logic [NUM_SRC-1:0]            src_used;
    logic [NUM_SRC-1:0]            stall_req;
    logic [NUM_SRC-1:0]            br_fwd;
    logic [NUM_SRC-1:0][1:0]       sel_now;

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] sel;
    } fwd_t;

    fwd_t fwd_d, fwd_q;
    logic enter_ex;

    assign src[0]      = id_rs1;
    assign src[1]      = id_rs2;
    assign src_used[0] = id_rs1_used && id_valid;
    assign src_used[1] = id_rs2_used && id_valid;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            hzd_src_chk #(.REG_W(REG_W)) u_src (
                .used      (src_used[g]),
                .src       (src[g]),
                .is_branch (id_branch),
                .ex_rd     (ex_rd),
                .ex_wr     (ex_wr),
                .ex_ld     (ex_ld),
                .mem_rd    (mem_rd),
                .mem_wr    (mem_wr),
                .mem_ld    (mem_ld),
                .stall_req (stall_req[g]),
                .fwd_sel   (sel_now[g]),
                .br_fwd    (br_fwd[g])
            );
        end
    endgenerate

    assign stall    = id_valid && (|stall_req);
    assign enter_ex = id_valid && !stall;

    hzd_stage_trk #(.REG_W(REG_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (enter_ex),
        .in_rd    (id_rd),
        .in_wr    (id_reg_write),
        .in_ld    (id_load),
        .ex_rd    (ex_rd),
        .ex_wr    (ex_wr),
        .ex_ld    (ex_ld),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_ld   (mem_ld)
    );

    hzd_branch_ctl u_br (
        .valid     (id_valid),
        .is_branch (id_branch),
        .taken     (id_br_taken),
        .stall     (stall),
        .flush     (flush),
        .pc_sel    (pc_sel)
    );

    always_comb begin
        fwd_d = fwd_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            fwd_d.sel[i] = enter_ex ? sel_now[i] : FWD_REGF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= fwd_d;
    end

    assign fwd_a    = fwd_q.sel[0];
    assign fwd_b    = fwd_q.sel[1];
    assign br_fwd_a = br_fwd[0];
    assign br_fwd_b = br_fwd[1];
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic [REG_W-1:0] id_rs1,
    input logic [REG_W-1:0] id_rs2,
    input logic             id_branch,
    input logic             stall,
    input logic             flush,
    input logic [1:0]       pc_sel,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             br_fwd_a,
    input logic             br_fwd_b
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    a_r12_stall_beats_flush: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !flush);

    a_r1_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> pc_sel == 2'd1);

    a_r1_bubble_selects: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

    a_r8_flush_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> pc_sel == 2'd2);

    a_r7_idle_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!stall && !flush && !br_fwd_a && !br_fwd_b));

    a_r5_zero_src_a: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_rs1 == ZERO_REG) |=> fwd_a == 2'd0);

    a_r5_zero_src_b: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_rs2 == ZERO_REG) |=> fwd_b == 2'd0);

    a_r11_cmp_bypass_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (br_fwd_a || br_fwd_b) |-> id_branch);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .id_branch (id_branch),
    .stall     (stall),
    .flush     (flush),
    .pc_sel    (pc_sel),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b),
    .br_fwd_a  (br_fwd_a),
    .br_fwd_b  (br_fwd_b)
);

// File: tb/hzd_ctrl_test.sv
module hzd_ctrl_test;
    localparam int REG_W = 5;
    localparam int NV    = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid = 1'b0;
    logic [REG_W-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic id_rs1_used = 1'b0, id_rs2_used = 1'b0;
    logic id_reg_write = 1'b0, id_load = 1'b0, id_branch = 1'b0, id_br_taken = 1'b0;
    logic stall, flush, br_fwd_a, br_fwd_b;
    logic [1:0] pc_sel, fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hzd_ctrl #(.REG_W(REG_W)) uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .id_rd(id_rd), .id_reg_write(id_reg_write), .id_load(id_load),
        .id_branch(id_branch), .id_br_taken(id_br_taken),
        .stall(stall), .flush(flush), .pc_sel(pc_sel),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b)
    );

    typedef struct packed {
        logic       v;
        logic [4:0] rs1, rs2;
        logic       u1, u2;
        logic [4:0] rd;
        logic       wr, ld, br, tk;
        logic       e_st, e_fl;
        logic [1:0] e_pc;
        logic       e_ba, e_bb;
        logic [1:0] e_fa, e_fb;
    } vec_t;

    // v rs1 rs2 u1 u2 rd wr ld br tk | stall flush pc bfa bfb | fa fb
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1,5'd2, 5'd3, 1'b1,1'b1,5'd1, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R4 none
        '{1'b1,5'd1, 5'd5, 1'b1,1'b1,5'd4, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd1,2'd0}, // R2 dist1
        '{1'b1,5'd1, 5'd7, 1'b1,1'b1,5'd6, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd2,2'd0}, // R3 dist2
        '{1'b1,5'd1, 5'd9, 1'b1,1'b1,5'd8, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R4 dist3
        '{1'b1,5'd6, 5'd8, 1'b1,1'b1,5'd10,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd2,2'd1}, // R2 R3 mixed
        '{1'b1,5'd10,5'd10,1'b1,1'b1,5'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd1,2'd1}, // R2 both, writes r0
        '{1'b1,5'd0, 5'd0, 1'b1,1'b1,5'd3, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R5 r0
        '{1'b1,5'd2, 5'd9, 1'b1,1'b1,5'd3, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R4
        '{1'b1,5'd3, 5'd3, 1'b1,1'b0,5'd11,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd1,2'd0}, // R6 youngest, R7 unused
        '{1'b1,5'd11,5'd0, 1'b1,1'b0,5'd12,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd1,2'd0}, // R2 load addr
        '{1'b1,5'd12,5'd11,1'b1,1'b1,5'd13,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,1'b0,1'b0, 2'd0,2'd0}, // R1 load-use
        '{1'b1,5'd12,5'd11,1'b1,1'b1,5'd13,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd2,2'd0}, // R1 replay
        '{1'b1,5'd13,5'd12,1'b1,1'b1,5'd12,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd1,2'd0}, // store
        '{1'b1,5'd13,5'd12,1'b1,1'b1,5'd14,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd2,2'd0}, // R7 store no source
        '{1'b1,5'd20,5'd21,1'b1,1'b1,5'd15,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R4
        '{1'b1,5'd15,5'd14,1'b1,1'b1,5'd0, 1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,2'd1,1'b0,1'b1, 2'd0,2'd0}, // R10 R12
        '{1'b1,5'd15,5'd14,1'b1,1'b1,5'd0, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,2'd2,1'b1,1'b0, 2'd0,2'd0}, // R8 R11
        '{1'b0,5'd15,5'd0, 1'b1,1'b0,5'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R7 squashed
        '{1'b1,5'd20,5'd0, 1'b1,1'b0,5'd16,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // load
        '{1'b0,5'd16,5'd0, 1'b1,1'b0,5'd17,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R7 invalid
        '{1'b1,5'd16,5'd0, 1'b1,1'b1,5'd0, 1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,2'd1,1'b0,1'b0, 2'd0,2'd0}, // R10 load in mem
        '{1'b1,5'd16,5'd0, 1'b1,1'b1,5'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}, // R9 not taken
        '{1'b1,5'd16,5'd16,1'b1,1'b1,5'd18,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0, 2'd0,2'd0}  // R4
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t w);
        id_valid = w.v;  id_rs1 = w.rs1; id_rs2 = w.rs2;
        id_rs1_used = w.u1; id_rs2_used = w.u2; id_rd = w.rd;
        id_reg_write = w.wr; id_load = w.ld; id_branch = w.br; id_br_taken = w.tk;
    endtask

    task automatic idle();
        id_valid = 0; id_rs1 = '0; id_rs2 = '0; id_rs1_used = 0; id_rs2_used = 0;
        id_rd = '0; id_reg_write = 0; id_load = 0; id_branch = 0; id_br_taken = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R13 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 stall", stall, 0);
        check("R13 flush", flush, 0);
        check("R13 pc_sel", pc_sel, 0);
        check("R13 fwd_a", fwd_a, 0);
        check("R13 fwd_b", fwd_b, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check($sformatf("row%0d stall (R1/R10/R12)", i), stall, VECS[i].e_st);
            check($sformatf("row%0d flush (R8/R12)", i), flush, VECS[i].e_fl);
            check($sformatf("row%0d pc_sel (R8/R9)", i), pc_sel, VECS[i].e_pc);
            check($sformatf("row%0d br_fwd_a (R11)", i), br_fwd_a, VECS[i].e_ba);
            check($sformatf("row%0d br_fwd_b (R11)", i), br_fwd_b, VECS[i].e_bb);
            @(posedge clk);
            #1;
            check($sformatf("row%0d fwd_a (R2/R3/R5/R6)", i), fwd_a, VECS[i].e_fa);
            check($sformatf("row%0d fwd_b (R2/R3/R4/R7)", i), fwd_b, VECS[i].e_fb);
        end

        // R10: branch waiting on a load in execute stalls two cycles
        @(negedge clk);
        idle();
        id_valid = 1; id_rs1 = 5'd25; id_rs1_used = 1; id_rd = 5'd25;
        id_reg_write = 1; id_load = 1;
        @(negedge clk);
        idle();
        id_valid = 1; id_branch = 1; id_br_taken = 1; id_rs2 = 5'd25; id_rs2_used = 1;
        #1;
        check("R10 branch on load in execute stall", stall, 1);
        check("R12 no flush while stalled", flush, 0);
        @(negedge clk);
        #1;
        check("R10 branch on load in memory stall", stall, 1);
        @(negedge clk);
        #1;
        check("R8 branch resolves after stall flush", flush, 1);
        check("R8 branch resolves pc_sel", pc_sel, 2);

        // R13: reset while a load is in flight clears the records
        @(negedge clk);
        idle();
        id_valid = 1; id_rs1 = 5'd26; id_rs1_used = 1; id_rd = 5'd26;
        id_reg_write = 1; id_load = 1;
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        id_valid = 1; id_rs1 = 5'd26; id_rs1_used = 1; id_rd = 5'd27; id_reg_write = 1;
        @(posedge clk);
        #1;
        check("R13 stall under reset", stall, 0);
        check("R13 fwd_a under reset", fwd_a, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R13 stall after reset", stall, 0);
        @(posedge clk);
        #1;
        check("R13 fwd_a after reset", fwd_a, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule